// File: doc/BRIEF.md
# Serial NAND Block Erase Sequencer

This block erases a run of consecutive 128 KiB erase blocks on a serial NAND flash. A request gives a start byte address and a byte length. The sequencer checks both values before it issues any command. It then visits each block in ascending order. For each block it first looks up the block's bad flag through an external bitmap port. If the block is good, it issues a write-enable, then the block-erase command carrying the block's row address. After that it polls the device status register until the device is no longer busy or the poll budget runs out.

Commands reach the flash through an existing serial shifter that takes one command per handshake. A command is a request carrying an opcode, an optional 24-bit address and a read flag. The shifter returns a completion pulse with the byte it read. When the run ends, the block raises `done` for one cycle. It also holds a 2-bit result code and the byte address of the block that failed, and both stay valid until the next request. Any failure after a request has been accepted sends a write-disable command before `done`.

Top module: `spi_nand_erase_seq`

## Requirements
- R1: A request whose start address or length has any of bits [16:0] set is rejected: `done` rises in the cycle after `start`, `err` = 3, `fail_addr` = the start address, and no command is issued.
- R2: A request whose address plus length exceeds BLOCKS × 128 KiB is rejected the same way as R1. A run that ends exactly at the device end is accepted.
- R3: An aligned request of length zero completes with `err` = 0 and issues no command.
- R4: The block number is address bits shifted right by 17. Each erase uses opcode 0xD8 with the address enabled, no read, and address = block number shifted left by 6. Blocks are erased in ascending order.
- R5: Each erase command is immediately preceded by a write-enable command, opcode 0x06, with no address.
- R6: When `bbt_bad` is high while `bbt_idx` names the current block, the run stops with `err` = 1 and `fail_addr` = that block's first byte address. No write-enable or erase is issued for that block.
- R7: If status bit 0 (busy) is set on POLL_MAX consecutive polls after one erase, the run stops with `err` = 3 and `fail_addr` = that block's address.
- R8: If a poll returns bit 0 clear and bit 2 (erase fail) set, the run stops with `err` = 2 and `fail_addr` = that block's address.
- R9: After any failure of an accepted request, exactly one write-disable command (opcode 0x04, no address) is issued before `done`. A successful run issues none.
- R10: A successful run ends with `err` = 0, `fail_addr` = 0, and `done` high for exactly one cycle, after which `busy` is low.
- R11: `cmd_req`, `cmd_opcode` and `cmd_addr` stay stable from the rise of `cmd_req` until the cycle in which `cmd_done` is seen.
- R12: Each status poll is opcode 0x0F with address 0xC00000 and the read flag set. Status bits 7:4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken while not busy |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | ADDR_W | Length in bytes |
| bbt_idx | output | BLK_W | Block number presented to the bad-block bitmap |
| bbt_bad | input | 1 | Bad flag for the block on `bbt_idx` |
| cmd_req | output | 1 | Command request to the serial shifter |
| cmd_opcode | output | 8 | Command opcode |
| cmd_addr | output | 24 | Command address |
| cmd_addr_en | output | 1 | Address phase present |
| cmd_read | output | 1 | Read one status byte after the address |
| cmd_done | input | 1 | Command completion pulse |
| cmd_rdata | input | 8 | Byte read by the completed command |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 ok, 1 bad block, 2 erase fail, 3 timeout or invalid |
| fail_addr | output | ADDR_W | Byte address of the failing block |

## Verification
Random runs of one to five blocks at random positions are mixed with directed runs. The random part varies the bad flags, the number of busy polls and the erase-fail status of each block, so a single stream exercises the bad-block stop, the fail stop and normal progress. Directed runs place the poll count exactly at the limit and one below it, which separates a timeout from a late success. They also put a run at the very end of the device, where an exact fit must be accepted and a one-block overrun rejected. Further directed runs use misaligned addresses, misaligned lengths and zero length; these must finish without any command. The bench counts commands by opcode and checks each erase row, so a skipped write-enable, a wrong row or a missing write-disable each show up as a separate mismatch.

// File: rtl/spi_nand_erase_seq.sv
module spi_nand_erase_seq #(
  parameter int ADDR_W    = 32,
  parameter int BLOCKS    = 1024,
  parameter int ERASE_LOG = 17,
  parameter int PAGES_LOG = 6,
  parameter int POLL_MAX  = 200,
  parameter int POLL_GAP  = 6250
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [ADDR_W-1:0]        req_len,
  output logic [$clog2(BLOCKS)-1:0] bbt_idx,
  input  logic                     bbt_bad,
  output logic                     cmd_req,
  output logic [7:0]               cmd_opcode,
  output logic [23:0]              cmd_addr,
  output logic                     cmd_addr_en,
  output logic                     cmd_read,
  input  logic                     cmd_done,
  input  logic [7:0]               cmd_rdata,
  output logic                     busy,
  output logic                     done,
  output logic [1:0]               err,
  output logic [ADDR_W-1:0]        fail_addr
);
  localparam int BLK_W  = $clog2(BLOCKS);
  localparam int PCNT_W = $clog2(POLL_MAX + 1);
  localparam int GCNT_W = $clog2(POLL_GAP + 1);
  localparam logic [ADDR_W:0]   DEV_BYTES  = (ADDR_W+1)'(BLOCKS) << ERASE_LOG;
  localparam logic [ADDR_W-1:0] BLK_BYTES  = ADDR_W'(1) << ERASE_LOG;
  localparam logic [PCNT_W-1:0] PCNT_LAST  = PCNT_W'(POLL_MAX - 1);
  localparam logic [GCNT_W-1:0] GCNT_LAST  = GCNT_W'(POLL_GAP - 1);
  localparam logic [7:0] OP_WREN = 8'h06, OP_ERASE = 8'hD8, OP_STAT = 8'h0F, OP_WRDI = 8'h04;
  localparam int ST_BUSY = 0, ST_EFAIL = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_WREN, S_ERASE, S_POLL, S_GAP, S_WRDI, S_DONE
  } state_t;

  state_t              st;
  logic [ADDR_W-1:0]   cur, rem;
  logic [PCNT_W-1:0]   pcnt;
  logic [GCNT_W-1:0]   gcnt;
  logic                misaligned, overflow, last_blk;
  logic [23:0]         row_addr;
  logic                unused_status;

  assign misaligned    = (|req_addr[ERASE_LOG-1:0]) | (|req_len[ERASE_LOG-1:0]);
  assign overflow      = ({1'b0, req_addr} + {1'b0, req_len}) > DEV_BYTES;
  assign last_blk      = rem == BLK_BYTES;
  assign bbt_idx       = cur[ERASE_LOG +: BLK_W];
  assign row_addr      = 24'({bbt_idx, {PAGES_LOG{1'b0}}});
  assign unused_status = ^{cmd_rdata[7:3], cmd_rdata[1]};

  assign busy        = st != S_IDLE;
  assign done        = st == S_DONE;
  assign cmd_req     = st inside {S_WREN, S_ERASE, S_POLL, S_WRDI};
  assign cmd_addr_en = st inside {S_ERASE, S_POLL};
  assign cmd_read    = st == S_POLL;

  always_comb begin
    cmd_opcode = 8'h00;
    cmd_addr   = 24'h0;
    case (st)
      S_WREN:  cmd_opcode = OP_WREN;
      S_ERASE: begin cmd_opcode = OP_ERASE; cmd_addr = row_addr; end
      S_POLL:  begin cmd_opcode = OP_STAT;  cmd_addr = 24'hC00000; end
      S_WRDI:  cmd_opcode = OP_WRDI;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cur       <= '0;
      rem       <= '0;
      pcnt      <= '0;
      gcnt      <= '0;
      err       <= 2'd0;
      fail_addr <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          err       <= 2'd0;
          fail_addr <= '0;
          cur       <= req_addr;
          rem       <= req_len;
          if (misaligned || overflow) begin
            err       <= 2'd3;
            fail_addr <= req_addr;
            st        <= S_DONE;
          end else if (req_len == '0) begin
            st <= S_DONE;
          end else begin
            st <= S_CHECK;
          end
        end
        S_CHECK: if (bbt_bad) begin
          err       <= 2'd1;
          fail_addr <= cur;
          st        <= S_WRDI;
        end else begin
          st <= S_WREN;
        end
        S_WREN: if (cmd_done) begin
          pcnt <= '0;
          st   <= S_ERASE;
        end
        S_ERASE: if (cmd_done) st <= S_POLL;
        S_POLL: if (cmd_done) begin
          if (!cmd_rdata[ST_BUSY]) begin
            if (cmd_rdata[ST_EFAIL]) begin
              err       <= 2'd2;
              fail_addr <= cur;
              st        <= S_WRDI;
            end else if (last_blk) begin
              st <= S_DONE;
            end else begin
              cur <= cur + BLK_BYTES;
              rem <= rem - BLK_BYTES;
              st  <= S_CHECK;
            end
          end else if (pcnt == PCNT_LAST) begin
            err       <= 2'd3;
            fail_addr <= cur;
            st        <= S_WRDI;
          end else begin
            pcnt <= pcnt + PCNT_W'(1);
            gcnt <= '0;
            st   <= S_GAP;
          end
        end
        S_GAP: if (gcnt == GCNT_LAST) st <= S_POLL;
               else gcnt <= gcnt + GCNT_W'(1);
        S_WRDI: if (cmd_done) st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_misaligned_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && ((|req_addr[ERASE_LOG-1:0]) || (|req_len[ERASE_LOG-1:0])))
    |=> (done && err == 2'd3 && !cmd_req));

  a_r2_overflow_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (({1'b0, req_addr} + {1'b0, req_len}) > DEV_BYTES))
    |=> (done && err == 2'd3 && !cmd_req));

  a_r3_zero_length: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && req_len == '0 && req_addr[ERASE_LOG-1:0] == '0 && {1'b0, req_addr} <= DEV_BYTES)
    |=> (done && err == 2'd0 && !cmd_req));

  a_r4_row_of_block: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_opcode == OP_ERASE)
    |-> (cmd_addr[PAGES_LOG-1:0] == '0 && cmd_addr[PAGES_LOG +: BLK_W] == bbt_idx && cmd_addr_en));

  a_r5_wren_before_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_opcode == OP_ERASE && !$past(cmd_req && cmd_opcode == OP_ERASE))
    |-> ($past(cmd_opcode) == OP_WREN && $past(cmd_done)));

  a_r9_cleanup_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_opcode == OP_WRDI && cmd_done) |=> (done && err != 2'd0));

  a_r11_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_done) |=> (cmd_req && $stable(cmd_opcode) && $stable(cmd_addr)));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/spi_nand_erase_seq_bench.sv
module spi_nand_erase_seq_bench;
  localparam int PM = 8;
  localparam longint DEV = 64'd1024 << 17;

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] req_addr = 0, req_len = 0;
  logic [9:0] bbt_idx;
  logic bbt_bad;
  logic cmd_req, cmd_addr_en, cmd_read, cmd_done = 0;
  logic [7:0] cmd_opcode, cmd_rdata = 0;
  logic [23:0] cmd_addr;
  logic busy, done;
  logic [1:0] err;
  logic [31:0] fail_addr;

  bit bad [0:1023];
  int pl_busy [0:15];
  bit pl_fail [0:15];
  int checks = 0, errors = 0;
  int n_wren, n_erase, n_wrdi, n_poll, k_erase, poll_in_blk;
  int order_bad, row_bad, fmt_bad, hold_bad, first_blk;
  logic [7:0] last_op;
  int e_err, e_erase, e_wrdi, e_poll;
  int unsigned e_fail;
  string e_tag;

  always #4 clk = ~clk;
  assign bbt_bad = bad[bbt_idx];

  spi_nand_erase_seq #(.POLL_MAX(PM), .POLL_GAP(3)) u_spi_nand_erase_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr), .req_len(req_len),
    .bbt_idx(bbt_idx), .bbt_bad(bbt_bad), .cmd_req(cmd_req), .cmd_opcode(cmd_opcode),
    .cmd_addr(cmd_addr), .cmd_addr_en(cmd_addr_en), .cmd_read(cmd_read),
    .cmd_done(cmd_done), .cmd_rdata(cmd_rdata), .busy(busy), .done(done),
    .err(err), .fail_addr(fail_addr));

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    logic [7:0] op, st;
    logic [23:0] ad;
    forever begin
      @(negedge clk);
      if (cmd_req) begin
        op = cmd_opcode; ad = cmd_addr; st = 8'h00;
        repeat ($urandom_range(0, 2)) begin
          @(negedge clk);
          if (!cmd_req || cmd_opcode != op || cmd_addr != ad) hold_bad++;
        end
        case (op)
          8'h06: begin n_wren++; if (cmd_addr_en || cmd_read) fmt_bad++; end
          8'hD8: begin
            if (last_op != 8'h06) order_bad++;
            if (ad != 24'((first_blk + k_erase) << 6) || !cmd_addr_en || cmd_read) row_bad++;
            k_erase++; poll_in_blk = 0; n_erase++;
          end
          8'h0F: begin
            if (ad != 24'hC00000 || !cmd_addr_en || !cmd_read) fmt_bad++;
            n_poll++;
            st = (poll_in_blk < pl_busy[k_erase-1]) ? 8'h01 : (pl_fail[k_erase-1] ? 8'h04 : 8'h00);
            st = st | (8'($urandom) & 8'hF0);
            poll_in_blk++;
          end
          8'h04: begin n_wrdi++; if (cmd_addr_en || cmd_read) fmt_bad++; end
          default: fmt_bad++;
        endcase
        last_op = op;
        cmd_rdata = st; cmd_done = 1;
        @(negedge clk);
        cmd_done = 0;
      end
    end
  end

  task automatic model(input int unsigned a, input int unsigned l);
    int unsigned b;
    e_err = 0; e_fail = 0; e_erase = 0; e_wrdi = 0; e_poll = 0; e_tag = "R10";
    if (a[16:0] != 0 || l[16:0] != 0) begin e_err = 3; e_fail = a; e_tag = "R1"; return; end
    if (longint'(a) + longint'(l) > DEV) begin e_err = 3; e_fail = a; e_tag = "R2"; return; end
    if (l == 0) begin e_tag = "R3"; return; end
    for (int k = 0; k < int'(l >> 17); k++) begin
      b = (a >> 17) + k;
      if (bad[b]) begin e_err = 1; e_fail = b << 17; e_wrdi = 1; e_tag = "R6"; return; end
      e_erase++;
      if (pl_busy[k] >= PM) begin e_poll += PM; e_err = 3; e_fail = b << 17; e_wrdi = 1; e_tag = "R7"; return; end
      e_poll += pl_busy[k] + 1;
      if (pl_fail[k]) begin e_err = 2; e_fail = b << 17; e_wrdi = 1; e_tag = "R8"; return; end
    end
  endtask

  task automatic run_op(input int unsigned a, input int unsigned l);
    int t = 0;
    model(a, l);
    n_wren = 0; n_erase = 0; n_wrdi = 0; n_poll = 0; k_erase = 0; poll_in_blk = 0;
    order_bad = 0; row_bad = 0; fmt_bad = 0; hold_bad = 0; last_op = 8'h00;
    first_blk = int'(a >> 17);
    @(negedge clk);
    start = 1; req_addr = a; req_len = l;
    @(negedge clk);
    start = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done, e_tag, "completion before watchdog", done, 1);
    chk(err == 2'(e_err), e_tag, "result code", err, e_err);
    chk(fail_addr == e_fail, e_tag, "failing address", fail_addr, e_fail);
    chk(n_erase == e_erase && row_bad == 0, "R4", "erase count / row errors", n_erase * 1000 + row_bad, e_erase * 1000);
    chk(n_wren == e_erase && order_bad == 0, "R5", "write-enable count / order errors", n_wren * 1000 + order_bad, e_erase * 1000);
    chk(n_wrdi == e_wrdi, "R9", "write-disable count", n_wrdi, e_wrdi);
    chk(n_poll == e_poll, "R7", "status poll count", n_poll, e_poll);
    chk(fmt_bad == 0, "R12", "command format errors", fmt_bad, 0);
    chk(hold_bad == 0, "R11", "unstable request", hold_bad, 0);
    @(negedge clk);
    chk(!done && !busy, "R10", "done/busy after completion", {done, busy}, 0);
  endtask

  task automatic clear_plan();
    for (int i = 0; i < 16; i++) begin pl_busy[i] = 1; pl_fail[i] = 0; end
  endtask

  initial begin
    int unsigned blk, nb;
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) bad[i] = 0;
    clear_plan();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cmd_req && err == 0 && fail_addr == 0, "R10", "reset state",
        {busy, done, cmd_req, err}, 0);
    rst_n = 1;
    @(negedge clk);

    pl_busy[0] = 2; pl_busy[1] = 0; pl_busy[2] = 3;
    run_op(32'h0, 32'h60000);
    run_op(32'h100, 32'h20000);
    run_op(32'h40000, 32'h20010);
    run_op(32'd1023 << 17, 32'h40000);
    clear_plan();
    run_op(32'd1022 << 17, 32'h40000);
    run_op(32'h0, 32'h0);
    bad[6] = 1;
    run_op(32'd5 << 17, 32'h80000);
    bad[6] = 0;
    clear_plan(); pl_busy[0] = PM;
    run_op(32'd9 << 17, 32'h40000);
    clear_plan(); pl_busy[0] = PM - 1;
    run_op(32'd9 << 17, 32'h20000);
    clear_plan(); pl_fail[1] = 1;
    run_op(32'd20 << 17, 32'h60000);

    for (int n = 0; n < 50; n++) begin
      clear_plan();
      blk = $urandom_range(0, 1023);
      nb = $urandom_range(1, 5);
      for (int k = 0; k < 16; k++) begin
        pl_busy[k] = ($urandom_range(0, 9) == 0) ? PM : $urandom_range(0, 3);
        pl_fail[k] = $urandom_range(0, 9) == 0;
      end
      for (int k = 0; k < int'(nb); k++)
        if (blk + k < 1024) bad[blk + k] = $urandom_range(0, 11) == 0;
      run_op(blk << 17, nb << 17);
      for (int k = 0; k < int'(nb); k++)
        if (blk + k < 1024) bad[blk + k] = 0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule